// File: doc/BRIEF.md
# Serial Channel Mode and Command Register Front End

This block is the register-side front end of a two-channel asynchronous serial controller. A byte-wide host bus reaches, for each channel, a set of mode registers, a clock-select byte, a write-only command byte, a read-only status byte and the data holding location. The block turns those accesses into configuration levels and one-cycle strobes for a separate transmitter/receiver core. Serialisation and deserialisation happen in that core. The core's live conditions and error events come back into this block as inputs.

The three mode registers share one address. A pointer picks which one the next access reaches. Each access to the mode address moves the pointer one step toward the last register, where it stays. Two command codes move the pointer back: one to the first framing register and one to the extended-options register. The upper address bit above the 3-bit offset selects the channel.

Top module: `sercmd_regfile`

## Requirements
- R1: Address bit 3 selects the channel and bits 2:0 select the offset. Offset 0 is the mode window. Offset 1 reads status and writes clock select. Offset 2 writes commands. Offset 3 reads received data and writes transmit data. A read of offsets 4 to 7 returns 0x00, and a write to them changes nothing.
- R2: In a command write, bit 0 enables receive, bit 1 disables receive, bit 2 enables transmit and bit 3 disables transmit. Each enable is a sticky flag that keeps its value until a later command changes it. When the disable bit and the enable bit for the same direction are both set in one write, the disable takes effect.
- R3: The command field in bits 7:4 produces one-cycle strobes on the channel's outputs in the cycle after the write. Code 2 strobes the receiver reset. Code 3 strobes the transmitter reset. Code 5 strobes the break-change clear.
- R4: Command code 6 sets the channel's line-break output. Command code 7 clears it.
- R5: Command code 1 points the mode window at framing register A. Command code 0xB points it at the options register. Every read or write of offset 0 reaches the register under the pointer and then moves the pointer: options goes to A, and A goes to B. The pointer stays on framing register B once it gets there.
- R6: In framing register A, bits 1:0 drive the data-bit code (0 means 5 bits and 3 means 8 bits). Bits 4:2 drive the parity code (0 even, 1 odd, 4 none).
- R7: In framing register B, bits 3:0 drive the stop code (0x7 means one stop bit and 0xF means two). In the options register, bit 3 drives the FIFO extension, bit 4 drives the half-level transmit threshold, and bits 2:0 drive the baud-table select.
- R8: The status byte carries receive ready in bit 0, FIFO full in bit 1, transmit ready in bit 2 and transmitter empty in bit 3. These four bits follow the core inputs directly.
- R9: Status bits 4 to 7 hold sticky flags for overrun, parity error, framing error and received break. Each is set by a one-cycle event input. Command 4 clears bits 4 to 6. Command 5 clears bit 7. Command 2 clears all four. When a clear and an event reach the same bit in the same cycle, the clear wins.
- R10: After reset, the pointer is on framing register A. Both enables are off. The error flags, the mode registers, the clock select and the line-break output are all zero.
- R11: A write to offset 3 raises that channel's transmit-push strobe for one cycle and presents the written byte. A read of offset 3 returns the core's received byte and asserts that channel's pop strobe during the same cycle as the read.
- R12: An access to one channel leaves every register and output of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Channel bit and register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| st_rx_ready | input | 2 | Core: received data available, per channel |
| st_fifo_full | input | 2 | Core: receive FIFO full |
| st_tx_ready | input | 2 | Core: transmit holding has room |
| st_tx_empty | input | 2 | Core: transmitter idle and empty |
| ev_overrun | input | 2 | Core: overrun event pulse |
| ev_parity | input | 2 | Core: parity error event pulse |
| ev_framing | input | 2 | Core: framing error event pulse |
| ev_break | input | 2 | Core: received break event pulse |
| rx_char | input | 16 | Core: received byte per channel |
| rx_enable | output | 2 | Receiver enabled |
| tx_enable | output | 2 | Transmitter enabled |
| rx_reset_stb | output | 2 | Receiver reset strobe |
| tx_reset_stb | output | 2 | Transmitter reset strobe |
| brk_flag_clr_stb | output | 2 | Break-change clear strobe |
| line_break | output | 2 | Force break on the line |
| data_bits | output | 4 | Data-bit code, 2 bits per channel |
| parity_sel | output | 6 | Parity code, 3 bits per channel |
| stop_sel | output | 8 | Stop code, 4 bits per channel |
| fifo_ext_en | output | 2 | Extended FIFO enable |
| tx_half_level | output | 2 | Half-level transmit threshold |
| baud_table | output | 6 | Baud table select, 3 bits per channel |
| clock_sel | output | 16 | Clock select byte per channel |
| tx_push | output | 2 | Transmit byte strobe |
| tx_char | output | 16 | Transmit byte per channel |
| rx_pop | output | 2 | Received byte consumed strobe |

## Verification
A pointer that is out of step shows up on the first mode access after a pointer command. The byte read back comes from the wrong register, and the framing outputs take a value on the next clock edge. A wrong enable or error flag appears in the enable outputs or the status byte one cycle after the write or event that caused it. A strobe that lasts too long, or that reaches the other channel, shows up on the sample taken one cycle after it should have dropped.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] OFF_MODE = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CMD  = 3'd2;
    localparam logic [2:0] OFF_HOLD = 3'd3;

    localparam logic [3:0] CMD_PTR_A   = 4'h1;
    localparam logic [3:0] CMD_RXRST   = 4'h2;
    localparam logic [3:0] CMD_TXRST   = 4'h3;
    localparam logic [3:0] CMD_ERRCLR  = 4'h4;
    localparam logic [3:0] CMD_BCHGCLR = 4'h5;
    localparam logic [3:0] CMD_BRKON   = 4'h6;
    localparam logic [3:0] CMD_BRKOFF  = 4'h7;
    localparam logic [3:0] CMD_PTR_OPT = 4'hB;

    typedef enum logic [1:0] {
        PTR_OPT = 2'd0,
        PTR_A   = 2'd1,
        PTR_B   = 2'd2
    } mode_ptr_e;

    typedef struct packed {
        mode_ptr_e          ptr;
        logic [BYTE_W-1:0]  opt;
        logic [BYTE_W-1:0]  fra;
        logic [BYTE_W-1:0]  frb;
        logic [BYTE_W-1:0]  csel;
        logic               rx_en;
        logic               tx_en;
        logic               brk;
        logic               rx_rst;
        logic               tx_rst;
        logic               bchg_clr;
        logic               push;
        logic [BYTE_W-1:0]  txd;
    } ctrl_state_t;

endpackage

// File: rtl/sercmd_chan_ctrl.sv
module sercmd_chan_ctrl
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              mode_re,
    input  logic              csel_we,
    input  logic              cmd_we,
    input  logic              thr_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] mode_rdata,
    output logic              clr_err,
    output logic              clr_brk,
    output logic              clr_all,
    output logic              rx_en_o,
    output logic              tx_en_o,
    output logic              rx_rst_o,
    output logic              tx_rst_o,
    output logic              bchg_clr_o,
    output logic              brk_o,
    output logic [1:0]        data_bits_o,
    output logic [2:0]        parity_o,
    output logic [3:0]        stop_o,
    output logic              fifo_ext_o,
    output logic              half_lvl_o,
    output logic [2:0]        baud_tbl_o,
    output logic [BYTE_W-1:0] csel_o,
    output logic              push_o,
    output logic [BYTE_W-1:0] txd_o
);

    ctrl_state_t s_d, s_q;
    logic [3:0]  cmd_field;

    assign cmd_field = wdata[7:4];

    always_comb begin
        s_d          = s_q;
        s_d.rx_rst   = 1'b0;
        s_d.tx_rst   = 1'b0;
        s_d.bchg_clr = 1'b0;
        s_d.push     = 1'b0;

        if (mode_we || mode_re) begin
            if (mode_we) begin
                case (s_q.ptr)
                    PTR_OPT: s_d.opt = wdata;
                    PTR_A:   s_d.fra = wdata;
                    default: s_d.frb = wdata;
                endcase
            end
            s_d.ptr = (s_q.ptr == PTR_OPT) ? PTR_A : PTR_B;
        end

        if (csel_we) begin
            s_d.csel = wdata;
        end

        if (thr_we) begin
            s_d.push = 1'b1;
            s_d.txd  = wdata;
        end

        if (cmd_we) begin
            if (wdata[1])      s_d.rx_en = 1'b0;
            else if (wdata[0]) s_d.rx_en = 1'b1;
            if (wdata[3])      s_d.tx_en = 1'b0;
            else if (wdata[2]) s_d.tx_en = 1'b1;

            case (cmd_field)
                CMD_PTR_A:   s_d.ptr      = PTR_A;
                CMD_PTR_OPT: s_d.ptr      = PTR_OPT;
                CMD_RXRST:   s_d.rx_rst   = 1'b1;
                CMD_TXRST:   s_d.tx_rst   = 1'b1;
                CMD_BCHGCLR: s_d.bchg_clr = 1'b1;
                CMD_BRKON:   s_d.brk      = 1'b1;
                CMD_BRKOFF:  s_d.brk      = 1'b0;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ptr <= PTR_A;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.ptr)
            PTR_OPT: mode_rdata = s_q.opt;
            PTR_A:   mode_rdata = s_q.fra;
            default: mode_rdata = s_q.frb;
        endcase
    end

    assign clr_err = cmd_we && (cmd_field == CMD_ERRCLR);
    assign clr_brk = cmd_we && (cmd_field == CMD_BCHGCLR);
    assign clr_all = cmd_we && (cmd_field == CMD_RXRST);

    assign rx_en_o     = s_q.rx_en;
    assign tx_en_o     = s_q.tx_en;
    assign rx_rst_o    = s_q.rx_rst;
    assign tx_rst_o    = s_q.tx_rst;
    assign bchg_clr_o  = s_q.bchg_clr;
    assign brk_o       = s_q.brk;
    assign data_bits_o = s_q.fra[1:0];
    assign parity_o    = s_q.fra[4:2];
    assign stop_o      = s_q.frb[3:0];
    assign fifo_ext_o  = s_q.opt[3];
    assign half_lvl_o  = s_q.opt[4];
    assign baud_tbl_o  = s_q.opt[2:0];
    assign csel_o      = s_q.csel;
    assign push_o      = s_q.push;
    assign txd_o       = s_q.txd;

    // R2: disable beats enable in the same write
    a_r2_rx_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wdata[1]) |=> !rx_en_o);

    // R5: pointer never takes the unused code
    a_r5_ptr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ptr != 2'b11);

    // R3: a receiver reset strobe always follows a matching command write
    a_r3_rxrst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_o |-> $past(cmd_we && (cmd_field == CMD_RXRST)));

    // R4: break-on command raises the break output
    a_r4_break_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (cmd_field == CMD_BRKON)) |=> brk_o);

endmodule

// File: rtl/sercmd_chan_status.sv
module sercmd_chan_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ev,       // overrun, parity, framing, break
    input  logic       clr_err,
    input  logic       clr_brk,
    input  logic       clr_all,
    output logic [3:0] flags
);

    logic [3:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q | ev;
        if (clr_err) flags_d[2:0] = 3'b000;
        if (clr_brk) flags_d[3]   = 1'b0;
        if (clr_all) flags_d      = 4'b0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    // R9: error clear takes priority over a same-cycle event
    a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_err || clr_all) |-> (flags_q[2:0] == 3'b000));

endmodule

// File: rtl/sercmd_regfile.sv
module sercmd_regfile
    import sercmd_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int ADDR_W = 3 + CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [NCH-1:0]      st_rx_ready,
    input  logic [NCH-1:0]      st_fifo_full,
    input  logic [NCH-1:0]      st_tx_ready,
    input  logic [NCH-1:0]      st_tx_empty,
    input  logic [NCH-1:0]      ev_overrun,
    input  logic [NCH-1:0]      ev_parity,
    input  logic [NCH-1:0]      ev_framing,
    input  logic [NCH-1:0]      ev_break,
    input  logic [NCH*8-1:0]    rx_char,
    output logic [NCH-1:0]      rx_enable,
    output logic [NCH-1:0]      tx_enable,
    output logic [NCH-1:0]      rx_reset_stb,
    output logic [NCH-1:0]      tx_reset_stb,
    output logic [NCH-1:0]      brk_flag_clr_stb,
    output logic [NCH-1:0]      line_break,
    output logic [NCH*2-1:0]    data_bits,
    output logic [NCH*3-1:0]    parity_sel,
    output logic [NCH*4-1:0]    stop_sel,
    output logic [NCH-1:0]      fifo_ext_en,
    output logic [NCH-1:0]      tx_half_level,
    output logic [NCH*3-1:0]    baud_table,
    output logic [NCH*8-1:0]    clock_sel,
    output logic [NCH-1:0]      tx_push,
    output logic [NCH*8-1:0]    tx_char,
    output logic [NCH-1:0]      rx_pop
);

    logic [2:0]        off;
    logic [CH_W-1:0]   chan;
    logic [NCH-1:0]    hit;
    logic [BYTE_W-1:0] mode_rd [NCH];
    logic [BYTE_W-1:0] stat_rd [NCH];

    assign off  = bus_addr[2:0];
    assign chan = bus_addr[ADDR_W-1:3];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic       clr_err, clr_brk, clr_all;
        logic [3:0] flags;

        assign hit[i] = (chan == CH_W'(i));

        sercmd_chan_ctrl u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_we     (bus_wr && hit[i] && (off == OFF_MODE)),
            .mode_re     (bus_rd && hit[i] && (off == OFF_MODE)),
            .csel_we     (bus_wr && hit[i] && (off == OFF_STAT)),
            .cmd_we      (bus_wr && hit[i] && (off == OFF_CMD)),
            .thr_we      (bus_wr && hit[i] && (off == OFF_HOLD)),
            .wdata       (bus_wdata),
            .mode_rdata  (mode_rd[i]),
            .clr_err     (clr_err),
            .clr_brk     (clr_brk),
            .clr_all     (clr_all),
            .rx_en_o     (rx_enable[i]),
            .tx_en_o     (tx_enable[i]),
            .rx_rst_o    (rx_reset_stb[i]),
            .tx_rst_o    (tx_reset_stb[i]),
            .bchg_clr_o  (brk_flag_clr_stb[i]),
            .brk_o       (line_break[i]),
            .data_bits_o (data_bits[i*2 +: 2]),
            .parity_o    (parity_sel[i*3 +: 3]),
            .stop_o      (stop_sel[i*4 +: 4]),
            .fifo_ext_o  (fifo_ext_en[i]),
            .half_lvl_o  (tx_half_level[i]),
            .baud_tbl_o  (baud_table[i*3 +: 3]),
            .csel_o      (clock_sel[i*8 +: 8]),
            .push_o      (tx_push[i]),
            .txd_o       (tx_char[i*8 +: 8])
        );

        sercmd_chan_status u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      ({ev_break[i], ev_framing[i], ev_parity[i], ev_overrun[i]}),
            .clr_err (clr_err),
            .clr_brk (clr_brk),
            .clr_all (clr_all),
            .flags   (flags)
        );

        assign stat_rd[i] = {flags, st_tx_empty[i], st_tx_ready[i],
                             st_fifo_full[i], st_rx_ready[i]};
        assign rx_pop[i]  = bus_rd && hit[i] && (off == OFF_HOLD);
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
                case (off)
                    OFF_MODE: bus_rdata = mode_rd[i];
                    OFF_STAT: bus_rdata = stat_rd[i];
                    OFF_HOLD: bus_rdata = rx_char[i*8 +: 8];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    // R11: at most one channel pops per read
    a_r11_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop));

    // R12: a strobe never fires on two channels from one write
    a_r12_rst_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_reset_stb) && $onehot0(tx_push));

endmodule

// File: tb/sercmd_regfile_test.sv
`timescale 1ns/1ps
module sercmd_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  st_rx_ready = '0, st_fifo_full = '0, st_tx_ready = '0, st_tx_empty = '0;
    logic [1:0]  ev_overrun = '0, ev_parity = '0, ev_framing = '0, ev_break = '0;
    logic [15:0] rx_char = '0;
    logic [1:0]  rx_enable, tx_enable, rx_reset_stb, tx_reset_stb, brk_flag_clr_stb;
    logic [1:0]  line_break, fifo_ext_en, tx_half_level, tx_push, rx_pop;
    logic [3:0]  data_bits;
    logic [5:0]  parity_sel, baud_table;
    logic [7:0]  stop_sel;
    logic [15:0] clock_sel, tx_char;

    int checks = 0, failures = 0;
    logic [1:0] last_pop;

    always #4 clk = ~clk;

    sercmd_regfile uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        last_pop = rx_pop;
        check(tag, {24'h0, bus_rdata}, {24'h0, exp});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_ev(logic [1:0] m);
        @(negedge clk);
        ev_overrun = m; ev_parity = m; ev_framing = m; ev_break = m;
        @(negedge clk);
        ev_overrun = '0; ev_parity = '0; ev_framing = '0; ev_break = '0;
    endtask

    // {read, addr, data}
    localparam int NV = 23;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 4'h0, 8'h02},  // R10: first mode write after reset lands in A
        {1'b0, 4'h2, 8'h10},
        {1'b1, 4'h0, 8'h02},
        {1'b0, 4'h2, 8'hB0},  // R5: point at options
        {1'b0, 4'h0, 8'h1D},
        {1'b0, 4'h0, 8'h13},
        {1'b0, 4'h0, 8'h0F},
        {1'b0, 4'h0, 8'h07},  // R5: stays on B
        {1'b0, 4'h2, 8'h10},
        {1'b1, 4'h0, 8'h13},
        {1'b1, 4'h0, 8'h07},
        {1'b1, 4'h0, 8'h07},
        {1'b0, 4'h2, 8'hB0},
        {1'b1, 4'h0, 8'h1D},
        {1'b0, 4'hA, 8'h10},  // R12: channel 1
        {1'b0, 4'h8, 8'h06},
        {1'b0, 4'hA, 8'h10},
        {1'b1, 4'h8, 8'h06},
        {1'b0, 4'h2, 8'h10},
        {1'b1, 4'h0, 8'h13},  // R12: channel 0 untouched
        {1'b0, 4'h6, 8'h55},  // R1: unused offset
        {1'b1, 4'h6, 8'h00},
        {1'b1, 4'h5, 8'h00}
    };

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 enables", {28'h0, rx_enable, tx_enable}, 32'h0);
        check("R10 config", {12'h0, clock_sel, data_bits}, 32'h0);
        check("R10 break", {30'h0, line_break}, 32'h0);
        do_rd(4'h1, 8'h00, "R10 status");

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][12]) do_rd(VEC[k][11:8], VEC[k][7:0], "R5/R1/R12 vector read");
            else            do_wr(VEC[k][11:8], VEC[k][7:0]);
        end
        check("R6 data bits", {28'h0, data_bits}, 32'hB);   // ch1=2, ch0=3
        check("R6 parity", {26'h0, parity_sel}, 32'h0C);    // ch1=1, ch0=4
        check("R7 stop", {24'h0, stop_sel}, 32'h07);
        check("R7 options", {24'h0, fifo_ext_en, tx_half_level, baud_table[2:0]}, 32'h2D);

        do_wr(4'h1, 8'h5C);
        check("R1 clock select", {16'h0, clock_sel}, 32'h005C);

        do_wr(4'h2, 8'h05);
        check("R2 enable both", {28'h0, rx_enable, tx_enable}, 32'h5);
        do_wr(4'h2, 8'h03);
        check("R2 disable wins", {28'h0, rx_enable, tx_enable}, 32'h1);
        do_wr(4'h2, 8'h0C);
        check("R2 tx disable wins", {28'h0, rx_enable, tx_enable}, 32'h0);
        do_wr(4'h2, 8'h01);
        do_wr(4'h2, 8'h00);
        check("R2 sticky", {28'h0, rx_enable, tx_enable}, 32'h4);

        do_wr(4'h2, 8'h20);
        check("R3 rx reset strobe", {30'h0, rx_reset_stb}, 32'h1);
        @(negedge clk);
        check("R3 rx reset one cycle", {30'h0, rx_reset_stb}, 32'h0);
        do_wr(4'hA, 8'h30);
        check("R3 tx reset strobe ch1", {28'h0, tx_reset_stb, rx_reset_stb}, 32'h8);
        @(negedge clk);
        check("R3 tx reset one cycle", {30'h0, tx_reset_stb}, 32'h0);

        do_wr(4'h2, 8'h60);
        check("R4 break on", {30'h0, line_break}, 32'h1);
        do_wr(4'h2, 8'h70);
        check("R4 break off", {30'h0, line_break}, 32'h0);

        st_rx_ready = 2'b01; st_tx_empty = 2'b01; st_tx_ready = 2'b10;
        do_rd(4'h1, 8'h09, "R8 live status ch0");
        do_rd(4'h9, 8'h04, "R8 live status ch1");

        pulse_ev(2'b01);
        do_rd(4'h1, 8'hF9, "R9 errors set");
        do_wr(4'h2, 8'h40);
        do_rd(4'h1, 8'h89, "R9 error clear keeps break");
        do_wr(4'h2, 8'h50);
        check("R3 break-change strobe", {30'h0, brk_flag_clr_stb}, 32'h1);
        do_rd(4'h1, 8'h09, "R9 break clear");
        pulse_ev(2'b01);
        do_wr(4'h2, 8'h20);
        do_rd(4'h1, 8'h09, "R9 rx reset clears all");
        do_rd(4'h9, 8'h04, "R12 ch1 status untouched");

        @(negedge clk);
        ev_overrun = 2'b01; bus_addr = 4'h2; bus_wdata = 8'h40; bus_wr = 1'b1;
        @(negedge clk);
        ev_overrun = 2'b00; bus_wr = 1'b0;
        do_rd(4'h1, 8'h09, "R9 clear wins over event");

        rx_char = 16'hC33C;
        do_rd(4'h3, 8'h3C, "R11 rx data ch0");
        check("R11 pop ch0", {30'h0, last_pop}, 32'h1);
        do_rd(4'hB, 8'hC3, "R11 rx data ch1");
        check("R11 pop ch1", {30'h0, last_pop}, 32'h2);

        do_wr(4'h3, 8'h77);
        check("R11 push ch0", {14'h0, tx_push, tx_char}, {14'h0, 2'b01, 8'h00, 8'h77});
        @(negedge clk);
        check("R11 push one cycle", {30'h0, tx_push}, 32'h0);
        do_wr(4'hB, 8'h88);
        check("R11 push ch1", {14'h0, tx_push, tx_char}, {14'h0, 2'b10, 8'h88, 8'h77});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule